// File: doc/BRIEF.md
# Application-Fair Row-Hit DRAM Request Scheduler

This block decides which pending memory request goes next to a single DRAM bank. Several applications running at the same time share one small request queue. Each slot stores the issuing application's ID, the row and column to access, and an age that grows while the request waits. The scheduler remembers which row is open in the bank. It serves requests that hit that row before any request that would force the row to close and a new one to open. When more than one request is in the winning hit class, the scheduler does not simply take the globally oldest one. It rotates priority over the application IDs, so a bandwidth-hungry application cannot starve a lighter one. Page hit rate stays the same as with the plain age-ordered policy.

Requests enter through a valid/ready port, and the input is not ready while the queue is full. A chosen request leaves the queue when it is decided. The grant port then carries it until the consumer accepts it. A grant for a row hit appears one cycle after the decision. A grant for a row switch appears after a fixed activate delay. A mode input falls back to the age-only baseline policy, so the two policies can be compared on the same trace. Per-application counters of row hits and row switches support that comparison.

Top module: `app_fair_row_sched`

## Requirements
- R1: When at least one queued request targets the open row, the decision picks one of those requests. A row switch is decided only when no queued request hits the open row.
- R2: With `base_mode` = 0, the winner within the best hit class is taken from the first application, counting upward from the rotation pointer and wrapping, that has a request in that class.
- R3: After a decision for application a, the rotation pointer becomes (a+1) modulo `NUM_APPS`.
- R4: An application with no request in the best hit class is passed over within the same decision, so no cycle is lost.
- R5: Among the candidates of one application, the request that has waited longest is chosen.
- R6: With `base_mode` = 1, the longest-waiting request in the best hit class wins, whatever its application.
- R7: `grant_valid` rises one cycle after a row-hit decision, and `ACT_DELAY` (default 4) cycles after a row-switch decision.
- R8: `in_ready` is 0 whenever all `DEPTH` (default 16) slots hold requests.
- R9: After reset the queue is empty, no row is open, the rotation pointer is 0, `in_ready` = 1, `grant_valid` = 0 and all counters read 0. The first decision after reset is therefore a row switch.
- R10: `hit_count` and `switch_count` hold one `CNT_W`-bit counter per application, with application a at bits [a*CNT_W +: CNT_W]. Each decision adds 1 to the decided application's hit or switch counter.
- R11: While `grant_valid` is 1 and `grant_ready` is 0, the grant fields hold their values and `grant_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_mode | input | 1 | 1: age-only baseline; 0: application rotation |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Queue can accept a request |
| in_app | input | 2 | Application ID of the request |
| in_row | input | ROW_W | Row address |
| in_col | input | COL_W | Column address |
| grant_valid | output | 1 | Chosen request ready to issue |
| grant_ready | input | 1 | Consumer accepts the grant |
| grant_app | output | 2 | Application ID of the grant |
| grant_row | output | ROW_W | Row of the grant |
| grant_col | output | COL_W | Column of the grant |
| hit_count | output | NUM_APPS*CNT_W | Per-application row-hit counts |
| switch_count | output | NUM_APPS*CNT_W | Per-application row-switch counts |

## Verification
The bench holds the grant port back and fills the queue with a mixed trace. In that trace, hits and misses to the open row come from both applications, and one application runs out of hits before the other. The trace is replayed in both modes. The rotating mode must interleave the applications, while the baseline must follow pure age order, and both must yield identical per-application hit and switch counts. Single requests sent into an idle scheduler separate hit latency from activate latency. A burst one larger than the queue shows where the input stalls and that nothing is lost.

// File: rtl/afrs_pkg.sv
package afrs_pkg;
  localparam int APP_W = 2;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ctl_state_t;

  // application that follows a in the rotation of n applications
  function automatic logic [APP_W-1:0] rr_next(input logic [APP_W-1:0] a, input int n);
    int s;
    s = int'(a) + 1;
    if (s >= n) s = 0;
    return APP_W'(s);
  endfunction

  // k-th application visited when the rotation starts at base
  function automatic logic [APP_W-1:0] rr_slot(input logic [APP_W-1:0] base, input int k,
                                               input int n);
    int s;
    s = int'(base) + k;
    if (s >= n) s = s - n;
    return APP_W'(s);
  endfunction

  // saturating increment of a waiting-time counter
  function automatic logic [7:0] age_inc(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction
endpackage

// File: rtl/afrs_queue.sv
module afrs_queue
  import afrs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [APP_W-1:0]                  wr_app,
  input  logic [ROW_W-1:0]                  wr_row,
  input  logic [COL_W-1:0]                  wr_col,
  input  logic                              rd_en,
  input  logic [IDX_W-1:0]                  rd_idx,
  output logic [DEPTH-1:0]                  q_valid,
  output logic [DEPTH-1:0][APP_W-1:0]       q_app,
  output logic [DEPTH-1:0][ROW_W-1:0]       q_row,
  output logic [DEPTH-1:0][COL_W-1:0]       q_col,
  output logic [DEPTH-1:0][7:0]             q_age,
  output logic                              full
);
  logic [IDX_W-1:0] free_idx;

  assign full = &q_valid;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!q_valid[i]) free_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= '0;
      q_app   <= '0;
      q_row   <= '0;
      q_col   <= '0;
      q_age   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rd_en && rd_idx == IDX_W'(i)) begin
          q_valid[i] <= 1'b0;
        end else if (q_valid[i]) begin
          q_age[i] <= age_inc(q_age[i]);
        end else if (wr_en && free_idx == IDX_W'(i)) begin
          q_valid[i] <= 1'b1;
          q_app[i]   <= wr_app;
          q_row[i]   <= wr_row;
          q_col[i]   <= wr_col;
          q_age[i]   <= 8'd0;
        end
      end
    end
  end
endmodule

// File: rtl/afrs_picker.sv
module afrs_picker
  import afrs_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int ROW_W    = 8,
  parameter int NUM_APPS = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]            q_valid,
  input  logic [DEPTH-1:0][APP_W-1:0] q_app,
  input  logic [DEPTH-1:0][ROW_W-1:0] q_row,
  input  logic [DEPTH-1:0][7:0]       q_age,
  input  logic                        row_open,
  input  logic [ROW_W-1:0]            open_row,
  input  logic [APP_W-1:0]            rr_ptr,
  input  logic                        base_mode,
  output logic                        any_hit,
  output logic                        pick_valid,
  output logic [IDX_W-1:0]            pick_idx
);
  logic [DEPTH-1:0] hit, cand;
  logic             g_found;
  logic [IDX_W-1:0] g_idx;
  logic [7:0]       g_age;
  logic             a_found [NUM_APPS];
  logic [IDX_W-1:0] a_idx   [NUM_APPS];
  logic [7:0]       a_age   [NUM_APPS];
  logic             r_found;
  logic [IDX_W-1:0] r_idx;

  always_comb begin
    any_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      hit[i]  = q_valid[i] && row_open && (q_row[i] == open_row);
      any_hit = any_hit | hit[i];
    end
    for (int i = 0; i < DEPTH; i++) cand[i] = q_valid[i] && (!any_hit || hit[i]);

    // oldest candidate overall
    g_found = 1'b0; g_idx = '0; g_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && (!g_found || q_age[i] > g_age)) begin
        g_found = 1'b1; g_idx = IDX_W'(i); g_age = q_age[i];
      end
    end

    // oldest candidate of each application
    for (int a = 0; a < NUM_APPS; a++) begin
      a_found[a] = 1'b0; a_idx[a] = '0; a_age[a] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (cand[i] && q_app[i] == APP_W'(a) && (!a_found[a] || q_age[i] > a_age[a])) begin
          a_found[a] = 1'b1; a_idx[a] = IDX_W'(i); a_age[a] = q_age[i];
        end
      end
    end

    // first application with a candidate, starting at the pointer
    r_found = 1'b0; r_idx = '0;
    for (int k = 0; k < NUM_APPS; k++) begin
      if (!r_found && a_found[int'(rr_slot(rr_ptr, k, NUM_APPS))]) begin
        r_found = 1'b1;
        r_idx   = a_idx[int'(rr_slot(rr_ptr, k, NUM_APPS))];
      end
    end

    pick_valid = base_mode ? g_found : r_found;
    pick_idx   = base_mode ? g_idx   : r_idx;
  end
endmodule

// File: rtl/afrs_stats.sv
module afrs_stats
  import afrs_pkg::*;
#(
  parameter int NUM_APPS = 2,
  parameter int CNT_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ev_valid,
  input  logic [APP_W-1:0]          ev_app,
  input  logic                      ev_hit,
  output logic [NUM_APPS*CNT_W-1:0] hit_count,
  output logic [NUM_APPS*CNT_W-1:0] switch_count
);
  for (genvar a = 0; a < NUM_APPS; a++) begin : g_app
    logic [CNT_W-1:0] hits, switches;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hits     <= '0;
        switches <= '0;
      end else if (ev_valid && ev_app == APP_W'(a)) begin
        if (ev_hit) hits <= hits + 1'b1;
        else        switches <= switches + 1'b1;
      end
    end
    assign hit_count[a*CNT_W +: CNT_W]    = hits;
    assign switch_count[a*CNT_W +: CNT_W] = switches;
  end
endmodule

// File: rtl/app_fair_row_sched.sv
module app_fair_row_sched
  import afrs_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int NUM_APPS  = 2,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int ACT_DELAY = 4,
  parameter int CNT_W     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      base_mode,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [1:0]                in_app,
  input  logic [ROW_W-1:0]          in_row,
  input  logic [COL_W-1:0]          in_col,
  output logic                      grant_valid,
  input  logic                      grant_ready,
  output logic [1:0]                grant_app,
  output logic [ROW_W-1:0]          grant_row,
  output logic [COL_W-1:0]          grant_col,
  output logic [NUM_APPS*CNT_W-1:0] hit_count,
  output logic [NUM_APPS*CNT_W-1:0] switch_count
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WC_W  = $clog2(ACT_DELAY + 1);

  logic [DEPTH-1:0]            q_valid;
  logic [DEPTH-1:0][APP_W-1:0] q_app;
  logic [DEPTH-1:0][ROW_W-1:0] q_row;
  logic [DEPTH-1:0][COL_W-1:0] q_col;
  logic [DEPTH-1:0][7:0]       q_age;
  logic                        q_full;

  ctl_state_t       state;
  logic [WC_W-1:0]  wait_cnt;
  logic             row_open;
  logic [ROW_W-1:0] open_row;
  logic [APP_W-1:0] rr_ptr;

  // named events for the checker
  logic             any_hit, pick_valid;
  logic [IDX_W-1:0] pick_idx;
  logic             grant_fire, can_decide, dec_fire, dec_hit;
  logic [APP_W-1:0] dec_app;

  assign in_ready    = !q_full;
  assign grant_valid = (state == ST_WAIT) && (wait_cnt == '0);
  assign grant_fire  = grant_valid && grant_ready;
  assign can_decide  = (state == ST_IDLE) || grant_fire;
  assign dec_fire    = can_decide && pick_valid;
  assign dec_app     = q_app[pick_idx];
  assign dec_hit     = row_open && (q_row[pick_idx] == open_row);

  afrs_queue #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .wr_en(in_valid && in_ready), .wr_app(in_app), .wr_row(in_row), .wr_col(in_col),
    .rd_en(dec_fire), .rd_idx(pick_idx),
    .q_valid(q_valid), .q_app(q_app), .q_row(q_row), .q_col(q_col), .q_age(q_age),
    .full(q_full)
  );

  afrs_picker #(.DEPTH(DEPTH), .ROW_W(ROW_W), .NUM_APPS(NUM_APPS)) u_picker (
    .q_valid(q_valid), .q_app(q_app), .q_row(q_row), .q_age(q_age),
    .row_open(row_open), .open_row(open_row), .rr_ptr(rr_ptr), .base_mode(base_mode),
    .any_hit(any_hit), .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  afrs_stats #(.NUM_APPS(NUM_APPS), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(dec_fire), .ev_app(dec_app), .ev_hit(dec_hit),
    .hit_count(hit_count), .switch_count(switch_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wait_cnt  <= '0;
      row_open  <= 1'b0;
      open_row  <= '0;
      rr_ptr    <= '0;
      grant_app <= '0;
      grant_row <= '0;
      grant_col <= '0;
    end else if (dec_fire) begin
      state     <= ST_WAIT;
      wait_cnt  <= dec_hit ? '0 : WC_W'(ACT_DELAY - 1);
      row_open  <= 1'b1;
      open_row  <= q_row[pick_idx];
      rr_ptr    <= rr_next(dec_app, NUM_APPS);
      grant_app <= dec_app;
      grant_row <= q_row[pick_idx];
      grant_col <= q_col[pick_idx];
    end else if (grant_fire) begin
      state <= ST_IDLE;
    end else if (state == ST_WAIT && wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/afrs_chk.sv
module afrs_chk
  import afrs_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int NUM_APPS  = 2,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int ACT_DELAY = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             grant_valid,
  input logic             grant_ready,
  input logic [1:0]       grant_app,
  input logic [ROW_W-1:0] grant_row,
  input logic [COL_W-1:0] grant_col,
  input logic             dec_fire,
  input logic             dec_hit,
  input logic             any_hit,
  input logic [APP_W-1:0] dec_app,
  input logic [APP_W-1:0] rr_ptr,
  input logic [DEPTH-1:0] q_valid
);
  // R1
  hit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire && any_hit |-> dec_hit);

  // R3
  rr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> rr_ptr == rr_next($past(dec_app), NUM_APPS));

  // R7
  hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire && dec_hit |=> grant_valid);

  if (ACT_DELAY > 1) begin : g_act
    // R7
    switch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_fire && !dec_hit |=> !grant_valid);
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(q_valid) == DEPTH) |-> !in_ready);

  // R11
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !grant_ready |=> grant_valid && $stable(grant_app)
                                    && $stable(grant_row) && $stable(grant_col));
endmodule

bind app_fair_row_sched afrs_chk #(
  .DEPTH(DEPTH), .NUM_APPS(NUM_APPS), .ROW_W(ROW_W), .COL_W(COL_W), .ACT_DELAY(ACT_DELAY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .grant_valid(grant_valid), .grant_ready(grant_ready),
  .grant_app(grant_app), .grant_row(grant_row), .grant_col(grant_col),
  .dec_fire(dec_fire), .dec_hit(dec_hit), .any_hit(any_hit),
  .dec_app(dec_app), .rr_ptr(rr_ptr), .q_valid(q_valid)
);

// File: tb/tb_app_fair_row_sched.sv
`timescale 1ns/1ps
module tb_app_fair_row_sched;
  localparam int DEPTH = 16, NUM_APPS = 2, ROW_W = 8, COL_W = 6, ACT_DELAY = 4, CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, base_mode = 1'b0;
  logic in_valid = 1'b0, in_ready, grant_valid, grant_ready = 1'b0;
  logic [1:0] in_app = '0, grant_app;
  logic [ROW_W-1:0] in_row = '0, grant_row;
  logic [COL_W-1:0] in_col = '0, grant_col;
  logic [NUM_APPS*CNT_W-1:0] hit_count, switch_count;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  app_fair_row_sched #(.DEPTH(DEPTH), .NUM_APPS(NUM_APPS), .ROW_W(ROW_W), .COL_W(COL_W),
                       .ACT_DELAY(ACT_DELAY), .CNT_W(CNT_W)) dut (.*);

  // shared trace: column i is request i, issued in order
  localparam logic [1:0]       TR_APP [6] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd0};
  localparam logic [ROW_W-1:0] TR_ROW [6] = '{8'd5, 8'd5, 8'd5, 8'd5, 8'd9, 8'd9};
  // vectors: mode, expected grant order (columns), expected hit0, sw0, hit1, sw1
  localparam int NV = 2;
  localparam logic V_MODE [NV] = '{1'b0, 1'b1};
  localparam int V_ORD [NV][6] = '{'{0, 3, 1, 2, 4, 5}, '{0, 1, 2, 3, 4, 5}};
  localparam int V_CNT [NV][4] = '{'{3, 1, 1, 1}, '{3, 1, 1, 1}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; grant_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [1:0] a, input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_app = a; in_row = r; in_col = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int cnt_of(input logic [NUM_APPS*CNT_W-1:0] v, input int a);
    return int'(v[a*CNT_W +: CNT_W]);
  endfunction

  // returns edges from enqueue edge until grant_valid is seen
  task automatic latency(input logic [1:0] a, input logic [ROW_W-1:0] r, output int n);
    @(negedge clk);
    in_valid = 1'b1; in_app = a; in_row = r; in_col = 6'd1;
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!grant_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #300000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int got [6];
    int ng, n;
    do_reset();
    @(negedge clk);
    // R9 reset state
    chk(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
    chk(grant_valid == 1'b0, "R9 grant_valid", int'(grant_valid), 0);
    chk(hit_count == '0 && switch_count == '0, "R9 counters", int'(hit_count), 0);

    // vector table: same trace under both modes
    for (int v = 0; v < NV; v++) begin
      do_reset();
      base_mode = V_MODE[v];
      for (int i = 0; i < 6; i++) push(TR_APP[i], TR_ROW[i], COL_W'(i));
      repeat (2) @(negedge clk);
      // R11 first grant held while not accepted
      chk(grant_valid && grant_col == 6'd0, "R11 held grant", int'(grant_col), 0);
      grant_ready = 1'b1;
      ng = 0;
      for (int t = 0; t < 100 && ng < 6; t++) begin
        if (grant_valid) begin got[ng] = int'(grant_col); ng++; end
        @(negedge clk);
      end
      grant_ready = 1'b0;
      // R1 R2 R3 R4 R5 R6 grant order
      for (int k = 0; k < 6; k++)
        chk(k < ng && got[k] == V_ORD[v][k],
            V_MODE[v] ? "R6 R1 baseline order" : "R2 R3 R4 R5 R1 rotation order",
            (k < ng) ? got[k] : -1, V_ORD[v][k]);
      // R10 counters, equal across modes
      chk(cnt_of(hit_count, 0) == V_CNT[v][0], "R10 hits app0", cnt_of(hit_count, 0), V_CNT[v][0]);
      chk(cnt_of(switch_count, 0) == V_CNT[v][1], "R10 switches app0", cnt_of(switch_count, 0), V_CNT[v][1]);
      chk(cnt_of(hit_count, 1) == V_CNT[v][2], "R10 hits app1", cnt_of(hit_count, 1), V_CNT[v][2]);
      chk(cnt_of(switch_count, 1) == V_CNT[v][3], "R10 switches app1", cnt_of(switch_count, 1), V_CNT[v][3]);
    end

    // R7 R9 latency: first request after reset is a switch, then a hit
    do_reset();
    base_mode = 1'b0;
    grant_ready = 1'b1;
    latency(2'd0, 8'd3, n);
    chk(n == ACT_DELAY, "R7 R9 switch latency", n, ACT_DELAY);
    repeat (3) @(negedge clk);
    latency(2'd1, 8'd3, n);
    chk(n == 1, "R7 hit latency", n, 1);
    chk(cnt_of(hit_count, 1) == 1 && cnt_of(switch_count, 0) == 1, "R10 latency counts",
        cnt_of(hit_count, 1), 1);

    // R8 full queue stalls the input
    do_reset();
    for (int i = 0; i < DEPTH + 1; i++) push(2'(i % 2), 8'(i), COL_W'(i));
    @(negedge clk);
    chk(in_ready == 1'b0, "R8 full stall", int'(in_ready), 0);
    grant_ready = 1'b1;
    ng = 0;
    for (int t = 0; t < 400 && ng < DEPTH + 1; t++) begin
      if (grant_valid) ng++;
      @(negedge clk);
    end
    chk(ng == DEPTH + 1, "R8 no request lost", ng, DEPTH + 1);
    chk(in_ready == 1'b1, "R8 ready after drain", int'(in_ready), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule